// File: doc/BRIEF.md
# Register-Programmed SPI Master with Byte FIFOs

This block is a serial peripheral interface master that software drives through a small 32-bit register bus. Software queues bytes into a 16-entry transmit FIFO. The shift engine sends each byte out on the data-out line and captures the byte that arrives at the same time into a 16-entry receive FIFO. Software then drains the receive FIFO through the receive-data register. Control bits select clock polarity, clock phase, bit order and an internal loopback path. A master-inhibit bit holds off transfers while data is queued. A manual-select bit decides whether the slave-select pins follow the select register directly or are asserted only while a frame shifts.

The shift engine is a state machine with five states. IDLE waits for a start. SETUP asserts the select, presents the first bit and holds the idle clock level for one half period. FIRST is the first half of a bit; the receive bit is sampled as it ends. SECOND is the second half of a bit. FINISH pushes the received byte and returns to IDLE.

The transitions are: IDLE to SETUP on start, SETUP to FIRST when the half-period counter expires, FIRST to SECOND on expiry, SECOND to FIRST on expiry for bits 0 to 6, SECOND to FINISH on expiry after bit 7, and FINISH to IDLE unconditionally. A soft reset returns the engine to IDLE from any state. The serial clock rate is fixed by the `CLK_DIV` parameter, which gives the number of system clocks per half period.

Top module: `mmio_spi_master`

## Requirements
- R1: After reset, control reads 0x180 (manual select and inhibit set), status reads 0x25, the select register reads all ones, both occupancy registers read 0, and sclk sits at 0.
- R2: Writing 0x0A to the soft-reset word at 0x40 restores every register and empties both FIFOs. A write of any other value to that word changes nothing.
- R3: A frame starts only when control bit 1 (enable) and bit 2 (master) are 1, bit 8 (inhibit) is 0, and the transmit FIFO is not empty. While inhibit is set, writes to the transmit-data word at 0x68 still queue bytes.
- R4: Each frame carries the low 8 bits of a queued byte, most significant bit first. With control bit 9 set, the least significant bit goes first, and received bits are placed in the same order.
- R5: sclk rests at control bit 3 (CPOL) when no frame is in progress. With control bit 4 (CPHA) at 0, data is sampled on the leading clock edge. With it at 1, data is sampled on the trailing edge. Each half period lasts CLK_DIV system clocks.
- R6: Every byte shifted out pushes the byte received at the same time into the receive FIFO. With control bit 0 (loopback) set, the received bits come from the block's own mosi instead of miso.
- R7: With control bit 7 set, ss_n equals the select register at 0x70. With bit 7 clear, ss_n is all ones except while a frame is in progress, when it equals the select register.
- R8: The transmit FIFO holds 16 bytes, and a write to it when full is dropped. Status bit 2 reports transmit empty and bit 3 reports transmit full. The word at 0x74 reads the entry count minus one, or 0 when the FIFO is empty.
- R9: Reading the receive-data word at 0x6C pops one byte, or returns 0 when the FIFO is empty. A byte received while the FIFO holds 16 is dropped. Status bit 0 reports receive empty and bit 1 reports receive full. The word at 0x78 reads the count minus one, or 0 when empty.
- R10: Writing control bit 5 empties the transmit FIFO and writing bit 6 empties the receive FIFO. Both bits read back as 0 afterwards.
- R11: The words at 0x1C, 0x20 and 0x28 read back what was last written to them. Status bit 4 always reads 0 and bit 5 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x6C) |
| reg_addr | input | 7 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The bench builds the block with CLK_DIV=2, NUM_SS=4 and FIFO_DEPTH=16. A frame then takes about 36 system clocks, so a run of seventeen back-to-back frames that overfills the receive FIFO stays short. At the same time the half period is long enough to watch every sclk edge separately against mosi in all four polarity and phase combinations. Sixteen-entry FIFOs keep the full, overflow-drop and occupancy-minus-one boundaries at the depth software actually sees.

// File: rtl/mspi_pkg.sv
package mspi_pkg;

    localparam int ADDR_W  = 7;
    localparam int FRAME_W = 8;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int CTRL_W  = 10;

    localparam logic [ADDR_W-1:0] A_GIE   = 7'h1C;
    localparam logic [ADDR_W-1:0] A_ISR   = 7'h20;
    localparam logic [ADDR_W-1:0] A_IER   = 7'h28;
    localparam logic [ADDR_W-1:0] A_SRST  = 7'h40;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h60;
    localparam logic [ADDR_W-1:0] A_STAT  = 7'h64;
    localparam logic [ADDR_W-1:0] A_TXD   = 7'h68;
    localparam logic [ADDR_W-1:0] A_RXD   = 7'h6C;
    localparam logic [ADDR_W-1:0] A_SEL   = 7'h70;
    localparam logic [ADDR_W-1:0] A_TXOCC = 7'h74;
    localparam logic [ADDR_W-1:0] A_RXOCC = 7'h78;

    localparam int C_LOOP  = 0;
    localparam int C_EN    = 1;
    localparam int C_MAST  = 2;
    localparam int C_CPOL  = 3;
    localparam int C_CPHA  = 4;
    localparam int C_TXCLR = 5;
    localparam int C_RXCLR = 6;
    localparam int C_MANSS = 7;
    localparam int C_INHIB = 8;
    localparam int C_LSB   = 9;

    localparam logic [CTRL_W-1:0] CTRL_RST = 10'h180;
    localparam logic [31:0]       SRST_KEY = 32'h0000_000A;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_FIRST,
        S_SECOND,
        S_FINISH
    } eng_state_t;

endpackage

// File: rtl/mspi_fifo.sv
module mspi_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == FULLC);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/mspi_engine.sv
module mspi_engine
    import mspi_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_byte,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               lsb_first,
    input  logic               loopback,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               busy,
    output logic               rx_valid,
    output logic [FRAME_W-1:0] rx_byte
);
    localparam int DW = $clog2(CLK_DIV) + 1;
    localparam logic [DW-1:0]    TICK_AT = DW'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    eng_state_t state, nxt;

    logic [DW-1:0]      cnt;
    logic [BIT_W-1:0]   bit_k;
    logic [BIT_W-1:0]   idx;
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic               tick;
    logic               rx_in;

    assign tick    = (cnt == TICK_AT);
    assign idx     = lsb_first ? bit_k : (LAST_BIT - bit_k);
    assign rx_in   = loopback ? mosi : miso;
    assign rx_byte = rx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else if (clr) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_SETUP;
            S_SETUP:  if (tick)  nxt = S_FIRST;
            S_FIRST:  if (tick)  nxt = S_SECOND;
            S_SECOND: if (tick)  nxt = (bit_k == LAST_BIT) ? S_FINISH : S_FIRST;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk     = cpol;
        mosi     = 1'b1;
        busy     = 1'b1;
        rx_valid = 1'b0;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_SETUP:  mosi = tx_q[idx];
            S_FIRST:  begin
                mosi = tx_q[idx];
                sclk = cpol ^ cpha;
            end
            S_SECOND: begin
                mosi = tx_q[idx];
                sclk = ~(cpol ^ cpha);
            end
            S_FINISH: rx_valid = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bit_k <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else if (clr) begin
            cnt   <= '0;
            bit_k <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (tick || state == S_IDLE || state == S_FINISH) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (state == S_IDLE && start) begin
                tx_q  <= tx_byte;
                bit_k <= '0;
            end
            if (state == S_FIRST && tick) begin
                rx_q[idx] <= rx_in;
            end
            if (state == S_SECOND && tick) begin
                bit_k <= bit_k + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mmio_spi_master.sv
module mmio_spi_master
    import mspi_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int NUM_SS     = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [CTRL_W-1:0]  ctrl_q;
    logic [NUM_SS-1:0]  sel_q;
    logic [31:0]        gie_q, isr_q, ier_q;
    logic               soft_hit;
    logic               wr_ctrl;

    logic [FRAME_W-1:0] tx_head, rx_head, rx_byte;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic               eng_busy, rx_valid, start;
    logic               tx_flush, rx_flush;

    assign soft_hit = reg_wr && (reg_addr == A_SRST) && (reg_wdata == SRST_KEY);
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign tx_flush = soft_hit || ctrl_q[C_TXCLR];
    assign rx_flush = soft_hit || ctrl_q[C_RXCLR];

    assign start = !eng_busy && ctrl_q[C_EN] && ctrl_q[C_MAST] &&
                   !ctrl_q[C_INHIB] && !ctrl_q[C_TXCLR] && !tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            sel_q  <= '1;
            gie_q  <= '0;
            isr_q  <= '0;
            ier_q  <= '0;
        end else if (soft_hit) begin
            ctrl_q <= CTRL_RST;
            sel_q  <= '1;
            gie_q  <= '0;
            isr_q  <= '0;
            ier_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= reg_wdata[CTRL_W-1:0];
            end else begin
                ctrl_q[C_TXCLR] <= 1'b0;
                ctrl_q[C_RXCLR] <= 1'b0;
            end
            if (reg_wr && reg_addr == A_SEL) sel_q <= reg_wdata[NUM_SS-1:0];
            if (reg_wr && reg_addr == A_GIE) gie_q <= reg_wdata;
            if (reg_wr && reg_addr == A_ISR) isr_q <= reg_wdata;
            if (reg_wr && reg_addr == A_IER) ier_q <= reg_wdata;
        end
    end

    mspi_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (reg_wr && reg_addr == A_TXD),
        .din   (reg_wdata[FRAME_W-1:0]),
        .pop   (start),
        .dout  (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    mspi_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (reg_rd && reg_addr == A_RXD),
        .dout  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    mspi_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_hit),
        .start     (start),
        .tx_byte   (tx_head),
        .cpol      (ctrl_q[C_CPOL]),
        .cpha      (ctrl_q[C_CPHA]),
        .lsb_first (ctrl_q[C_LSB]),
        .loopback  (ctrl_q[C_LOOP]),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (eng_busy),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte)
    );

    assign ss_n = (ctrl_q[C_MANSS] || eng_busy) ? sel_q : '1;

    function automatic logic [31:0] occ(input logic [CW-1:0] c);
        return (c == '0) ? 32'd0 : 32'(c - 1'b1);
    endfunction

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_GIE:   reg_rdata = gie_q;
            A_ISR:   reg_rdata = isr_q;
            A_IER:   reg_rdata = ier_q;
            A_CTRL:  reg_rdata = 32'(ctrl_q);
            A_STAT:  reg_rdata = {26'd0, 1'b1, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
            A_RXD:   reg_rdata = 32'(rx_head);
            A_SEL:   reg_rdata = 32'(sel_q);
            A_TXOCC: reg_rdata = occ(tx_cnt);
            A_RXOCC: reg_rdata = occ(rx_cnt);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mspi_checker.sv
module mspi_checker
    import mspi_pkg::*;
#(
    parameter int NUM_SS = 4,
    parameter int DEPTH  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [6:0]                 reg_addr,
    input logic [31:0]                reg_wdata,
    input logic                       sclk,
    input logic [NUM_SS-1:0]          ss_n,
    input logic [CTRL_W-1:0]          ctrl_q,
    input logic                       eng_busy,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt
);
    // R2
    soft_reset_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SRST && reg_wdata == SRST_KEY) |=> (ctrl_q == CTRL_RST && ss_n == '1));

    // R3
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(ctrl_q[C_EN] && ctrl_q[C_MAST] && !ctrl_q[C_INHIB]));

    // R5
    sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (sclk == ctrl_q[C_CPOL]));

    // R7
    auto_select_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_MANSS] && !eng_busy) |-> (ss_n == '1));

    // R8
    tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    // R10
    fifo_clear_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[C_TXCLR] || ctrl_q[C_RXCLR]) && !(reg_wr && reg_addr == A_CTRL))
        |=> (!ctrl_q[C_TXCLR] && !ctrl_q[C_RXCLR]));

endmodule

bind mmio_spi_master mspi_checker #(.NUM_SS(NUM_SS), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sclk      (sclk),
    .ss_n      (ss_n),
    .ctrl_q    (ctrl_q),
    .eng_busy  (eng_busy),
    .tx_cnt    (tx_cnt)
);

// File: tb/mmio_spi_master_tb.sv
module mmio_spi_master_tb;
    localparam int NSS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [NSS-1:0] ss_n;

    int n_chk = 0;
    int n_fail = 0;

    // slave model state
    logic       m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0, mon_on = 1'b0;
    logic [7:0] mo_byte = '0, cap_byte = '0;
    logic [7:0] cap_mem [32];
    int         mon_n = 0, cap_cnt = 0, edge_cnt = 0;

    always #5 clk = ~clk;

    mmio_spi_master #(.CLK_DIV(2), .NUM_SS(NSS), .FIFO_DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always @(sclk) begin
        if (ss_n != '1) begin
            edge_cnt++;
            if (mon_on && ((sclk == m_cpol) == m_cpha)) begin
                cap_byte[m_lsb ? mon_n : 7 - mon_n] = mosi;
                mon_n++;
                if (mon_n == 8) begin
                    cap_mem[cap_cnt % 32] = cap_byte;
                    cap_cnt++;
                    mon_n = 0;
                end
                miso = mo_byte[m_lsb ? mon_n : 7 - mon_n];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [31:0] cfg(input logic cp, input logic ch, input logic lsb, input logic lp);
        return 32'h006 | (32'(cp) << 3) | (32'(ch) << 4) | (32'(lsb) << 9) | 32'(lp);
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(7'h60, v); check("R1 ctrl", v, 32'h180);
        rd(7'h64, v); check("R1 status", v, 32'h25);
        rd(7'h70, v); check("R1 select", v, 32'hF);
        rd(7'h74, v); check("R1 txocc", v, 0);
        rd(7'h78, v); check("R1 rxocc", v, 0);
        check("R1 sclk", 32'(sclk), 0);
    endtask

    task automatic t_mode(input logic cp, input logic ch, input logic lsb,
                          input logic [7:0] txb, input logic [7:0] rxb);
        logic [31:0] v;
        mon_on = 1'b0;
        wr(7'h70, 32'hE);
        wr(7'h60, cfg(cp, ch, lsb, 1'b0) | 32'h100);
        idle(2);
        m_cpol = cp; m_cpha = ch; m_lsb = lsb; mo_byte = rxb;
        mon_n = 0; cap_cnt = 0;
        miso = rxb[lsb ? 0 : 7];
        mon_on = 1'b1;
        wr(7'h68, 32'(txb));
        wr(7'h60, cfg(cp, ch, lsb, 1'b0));
        idle(60);
        check("R4 R5 mosi frame", 32'(cap_mem[0]), 32'(txb));
        check("R5 one frame", cap_cnt, 1);
        rd(7'h6C, v); check("R6 R4 rx byte", v, 32'(rxb));
        check("R5 idle sclk", 32'(sclk), 32'(cp));
        mon_on = 1'b0;
    endtask

    task automatic t_loop;
        logic [31:0] v;
        mon_on = 1'b0; miso = 1'b0;
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1));
        wr(7'h68, 32'h15A);
        idle(60);
        rd(7'h6C, v); check("R6 loopback", v, 32'h5A);
    endtask

    task automatic t_inhibit;
        logic [31:0] v;
        int e0;
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1) | 32'h100);
        e0 = edge_cnt;
        wr(7'h68, 32'h11); wr(7'h68, 32'h22); wr(7'h68, 32'h33);
        idle(100);
        rd(7'h74, v); check("R3 queued under inhibit", v, 2);
        check("R3 no sclk under inhibit", edge_cnt - e0, 0);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1) & ~32'h2);
        idle(80);
        rd(7'h74, v); check("R3 held without enable", v, 2);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1));
        idle(140);
        rd(7'h78, v); check("R3 three frames", v, 2);
        rd(7'h6C, v); check("R3 first rx", v, 32'h11);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1) | 32'h40);
        idle(2);
        rd(7'h64, v); check("R10 rx cleared", v & 32'h1, 1);
    endtask

    task automatic t_txfull;
        logic [31:0] v;
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1) | 32'h100);
        for (int i = 0; i < 17; i++) wr(7'h68, 32'(8'h40 + i));
        rd(7'h64, v); check("R8 tx full flag", v & 32'hC, 32'h8);
        rd(7'h74, v); check("R8 tx occupancy", v, 15);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1) | 32'h120);
        idle(2);
        rd(7'h64, v); check("R10 tx cleared", v & 32'hC, 32'h4);
        rd(7'h60, v); check("R10 self clear", v & 32'h60, 0);
    endtask

    task automatic t_rx;
        logic [31:0] v;
        rd(7'h6C, v); check("R9 empty read", v, 0);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 17; i++) wr(7'h68, 32'(8'h10 + i));
        idle(17 * 45);
        rd(7'h64, v); check("R9 rx full flag", v & 32'h3, 32'h2);
        rd(7'h78, v); check("R9 rx occupancy", v, 15);
        for (int i = 0; i < 16; i++) begin
            rd(7'h6C, v);
            if (i == 0 || i == 15) check("R9 rx order", v, 32'(8'h10 + i));
        end
        rd(7'h6C, v); check("R9 17th dropped", v, 0);
    endtask

    task automatic t_select;
        logic [31:0] v;
        wr(7'h70, 32'hB);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1));
        idle(3);
        check("R7 auto idle", 32'(ss_n), 32'hF);
        wr(7'h68, 32'h77);
        idle(10);
        check("R7 auto active", 32'(ss_n), 32'hB);
        idle(50);
        check("R7 auto released", 32'(ss_n), 32'hF);
        rd(7'h6C, v);
        wr(7'h60, cfg(1'b0, 1'b0, 1'b0, 1'b1) | 32'h80);
        idle(2);
        check("R7 manual", 32'(ss_n), 32'hB);
    endtask

    task automatic t_soft;
        logic [31:0] v;
        wr(7'h60, 32'h01F);
        wr(7'h70, 32'h0);
        wr(7'h40, 32'h05);
        rd(7'h60, v); check("R2 wrong key ignored", v, 32'h1F);
        wr(7'h40, 32'h0A);
        rd(7'h60, v); check("R2 ctrl restored", v, 32'h180);
        rd(7'h70, v); check("R2 select restored", v, 32'hF);
        rd(7'h64, v); check("R2 status restored", v, 32'h25);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(7'h1C, 32'h8000_0000);
        wr(7'h20, 32'h0000_0005);
        wr(7'h28, 32'h0000_003F);
        rd(7'h1C, v); check("R11 gie", v, 32'h8000_0000);
        rd(7'h20, v); check("R11 isr", v, 32'h5);
        rd(7'h28, v); check("R11 ier", v, 32'h3F);
        rd(7'h64, v); check("R11 fixed status bits", v & 32'h30, 32'h20);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        idle(150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        #2 rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mode(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
        t_mode(1'b0, 1'b1, 1'b0, 8'h96, 8'hC3);
        t_mode(1'b1, 1'b0, 1'b0, 8'h1E, 8'h81);
        t_mode(1'b1, 1'b1, 1'b1, 8'h0D, 8'hB0);
        t_mode(1'b0, 1'b0, 1'b1, 8'h01, 8'h80);
        t_loop();
        t_inhibit();
        t_txfull();
        t_rx();
        t_select();
        t_irq();
        t_soft();
        finish_run();
    end

endmodule